// File: doc/BRIEF.md
# Store-to-Load Edge Predictor with Edge-Name Renaming

This block lets a load receive its value from the store that fed it, through the register rename path rather than through memory. Only instruction addresses are used, so a prediction is ready early in the pipeline. A training port reports an observed pair: a load PC and the PC of the store that actually supplied it. The pair is kept in a direct-mapped table indexed by the load PC. Each distinct sourcing store owns a short edge name, and all loads trained against that store share the same name.

A store lookup returns the edge name the store owns, if it has one. On that lookup the block records the store's destination physical register in the edge's mapping entry. A later load lookup returns the predicted store PC, the edge name and, once a store has filled the entry, the physical register to use as the load's source. Edge names come from a small pool with least-recently-used replacement. Reassigning a name drops its old mapping in the same cycle. A load that misses gets no prediction and takes the ordinary memory path.

Lookups are combinational from the stored state. Training, mapping writes and recency updates take effect at the next rising clock edge.

Top module: `memdep_edge_rename`

## Requirements
- R1: After reset no edge exists. Every load and store lookup misses. Successive new stores receive edge names in descending order, starting from the highest name (2^EDGE_W - 1).
- R2: After training with (load PC, store PC), a load lookup of that load PC gives `ld_hit`=1 and `ld_store_pc` equal to the trained store PC.
- R3: A load PC with the same index bits but a different tag field misses.
- R4: Training with a store PC that already owns an edge reuses that edge name. All loads trained to that store report the same `ld_edge`.
- R5: Training with a store PC that owns no edge gives it the least-recently-used edge name. From the next cycle, the previous owner's store lookups and every load predicted to it miss.
- R6: When a name is reassigned, its mapping entry becomes invalid in the same edge. A load on the new edge reports `ld_src_valid`=0 until a store fills it.
- R7: A store lookup that hits writes `st_phys` into its edge's mapping. From the next cycle, loads on that edge report `ld_src_valid`=1 and `ld_src_phys` equal to that value.
- R8: A store lookup with no edge reports `st_hit`=0 and changes no mapping and no recency order.
- R9: Recency: a training event makes its edge the most recent. A store hit does the same, except in a cycle that also trains, where only the trained edge is updated.
- R10: On a miss, `ld_store_pc`, `ld_edge`, `ld_src_valid` and `ld_src_phys` are all zero. `st_edge` is zero when `st_hit` is 0. `ld_src_phys` is zero whenever `ld_src_valid` is 0.
- R11: The table index is PC bits [2 +: IDX_W]. The tag is the TAG_W bits directly above the index.
- R12: If a training event reassigns the very edge that a same-cycle store lookup hits, the invalidation wins and the mapping ends up invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trn_valid | input | 1 | Training pair present |
| trn_load_pc | input | PC_W | PC of the load being trained |
| trn_store_pc | input | PC_W | PC of the store that actually sourced it |
| ld_req | input | 1 | Load lookup request |
| ld_pc | input | PC_W | Load PC to look up |
| ld_hit | output | 1 | Load has a live prediction |
| ld_store_pc | output | PC_W | Predicted sourcing store PC |
| ld_edge | output | EDGE_W | Predicted edge name |
| ld_src_valid | output | 1 | Mapping entry holds a physical register |
| ld_src_phys | output | PHYS_W | Physical register to read as source |
| st_req | input | 1 | Store lookup request |
| st_pc | input | PC_W | Store PC to look up |
| st_phys | input | PHYS_W | Store's destination physical register |
| st_hit | output | 1 | Store owns an edge |
| st_edge | output | EDGE_W | Edge name owned by the store |

## Verification
Directed sequences separate the cases one at a time:
- a fresh store versus a store that already owns an edge, which shows reuse versus allocation;
- the same index with a different tag, and the same tag at a different index, which shows that the aliases are rejected on the correct fields;
- a store lookup with no edge, which shows it has no side effects;
- a run of allocations long enough to wrap the whole name pool, which shows whether a recent store touch protects a name from eviction.

One directed cycle trains a new store and, in the same cycle, hits the store that owns the name being evicted, to pin down which of the two writes wins. A long random phase then draws from small pools of load PCs and store PCs so that aliasing, reuse and eviction happen often. A queue-based recency model checks every output on every cycle.

// File: rtl/memdep_edge_rename.sv
module memdep_edge_rename #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 6,
  parameter int EDGE_W = 5,
  parameter int PHYS_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trn_valid,
  input  logic [PC_W-1:0]   trn_load_pc,
  input  logic [PC_W-1:0]   trn_store_pc,
  input  logic              ld_req,
  input  logic [PC_W-1:0]   ld_pc,
  output logic              ld_hit,
  output logic [PC_W-1:0]   ld_store_pc,
  output logic [EDGE_W-1:0] ld_edge,
  output logic              ld_src_valid,
  output logic [PHYS_W-1:0] ld_src_phys,
  input  logic              st_req,
  input  logic [PC_W-1:0]   st_pc,
  input  logic [PHYS_W-1:0] st_phys,
  output logic              st_hit,
  output logic [EDGE_W-1:0] st_edge
);

  localparam int SETS    = 1 << IDX_W;
  localparam int EDGE_N  = 1 << EDGE_W;
  localparam int TAG_LSB = 2 + IDX_W;

  logic [SETS-1:0]   lt_v;
  logic [TAG_W-1:0]  lt_tag  [SETS];
  logic [PC_W-1:0]   lt_spc  [SETS];
  logic [EDGE_W-1:0] lt_edge [SETS];

  logic [EDGE_N-1:0]             own_v;
  logic [PC_W-1:0]               own_pc [EDGE_N];
  logic [EDGE_N-1:0]             ren_v;
  logic [EDGE_N-1:0][PHYS_W-1:0] ren_p;
  logic [EDGE_N-1:0][EDGE_W-1:0] age;

  logic [EDGE_N-1:0] st_match, tr_match;
  logic [EDGE_W-1:0] st_e, tr_e, lru_e;

  always_comb begin
    st_e  = '0;
    tr_e  = '0;
    lru_e = '0;
    for (int e = 0; e < EDGE_N; e++) begin
      st_match[e] = own_v[e] && (own_pc[e] == st_pc);
      tr_match[e] = own_v[e] && (own_pc[e] == trn_store_pc);
      if (st_match[e]) st_e = EDGE_W'(e);
      if (tr_match[e]) tr_e = EDGE_W'(e);
      if (age[e] == EDGE_W'(EDGE_N - 1)) lru_e = EDGE_W'(e);
    end
  end

  logic [IDX_W-1:0]  ld_idx, tr_idx;
  logic [EDGE_W-1:0] ld_e;
  logic              ld_raw;

  assign ld_idx = ld_pc[2 +: IDX_W];
  assign tr_idx = trn_load_pc[2 +: IDX_W];
  assign ld_e   = lt_edge[ld_idx];
  assign ld_raw = lt_v[ld_idx] && (lt_tag[ld_idx] == ld_pc[TAG_LSB +: TAG_W])
                  && own_v[ld_e] && (own_pc[ld_e] == lt_spc[ld_idx]);

  assign ld_hit       = ld_req && ld_raw;
  assign ld_store_pc  = ld_hit ? lt_spc[ld_idx] : '0;
  assign ld_edge      = ld_hit ? ld_e : '0;
  assign ld_src_valid = ld_hit && ren_v[ld_e];
  assign ld_src_phys  = ld_src_valid ? ren_p[ld_e] : '0;

  assign st_hit  = st_req && (|st_match);
  assign st_edge = st_hit ? st_e : '0;

  logic              alloc, touch, st_write;
  logic [EDGE_W-1:0] trn_edge, touch_e;

  assign alloc    = trn_valid && !(|tr_match);
  assign trn_edge = (|tr_match) ? tr_e : lru_e;
  assign touch    = trn_valid || st_hit;
  assign touch_e  = trn_valid ? trn_edge : st_e;
  assign st_write = st_hit && !(alloc && (lru_e == st_e));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lt_v  <= '0;
      own_v <= '0;
      ren_v <= '0;
      ren_p <= '0;
      for (int s = 0; s < SETS; s++) begin
        lt_tag[s]  <= '0;
        lt_spc[s]  <= '0;
        lt_edge[s] <= '0;
      end
      for (int e = 0; e < EDGE_N; e++) begin
        own_pc[e] <= '0;
        age[e]    <= EDGE_W'(e);
      end
    end else begin
      if (trn_valid) begin
        lt_v[tr_idx]    <= 1'b1;
        lt_tag[tr_idx]  <= trn_load_pc[TAG_LSB +: TAG_W];
        lt_spc[tr_idx]  <= trn_store_pc;
        lt_edge[tr_idx] <= trn_edge;
      end
      if (st_write) begin
        ren_v[st_e] <= 1'b1;
        ren_p[st_e] <= st_phys;
      end
      if (alloc) begin
        own_v[lru_e]  <= 1'b1;
        own_pc[lru_e] <= trn_store_pc;
        ren_v[lru_e]  <= 1'b0;
      end
      if (touch) begin
        for (int e = 0; e < EDGE_N; e++) begin
          if (EDGE_W'(e) == touch_e)
            age[e] <= '0;
          else if (age[e] < age[touch_e])
            age[e] <= age[e] + EDGE_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/memdep_edge_rename_chk.sv
module memdep_edge_rename_chk #(
  parameter int PC_W   = 32,
  parameter int EDGE_W = 5,
  parameter int PHYS_W = 6
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 ld_hit,
  input logic [PC_W-1:0]                      ld_store_pc,
  input logic [EDGE_W-1:0]                    ld_edge,
  input logic                                 ld_src_valid,
  input logic                                 st_hit,
  input logic [EDGE_W-1:0]                    st_edge,
  input logic [PHYS_W-1:0]                    st_phys,
  input logic [(1<<EDGE_W)-1:0]               own_v,
  input logic [(1<<EDGE_W)-1:0]               ren_v,
  input logic [(1<<EDGE_W)-1:0][PHYS_W-1:0]   ren_p,
  input logic [(1<<EDGE_W)-1:0][EDGE_W-1:0]   age,
  input logic                                 alloc,
  input logic [EDGE_W-1:0]                    lru_e,
  input logic                                 touch,
  input logic [EDGE_W-1:0]                    touch_e
);
  localparam int EDGE_N = 1 << EDGE_W;

  logic [EDGE_N-1:0] seen;
  always_comb begin
    seen = '0;
    for (int e = 0; e < EDGE_N; e++) seen[age[e]] = 1'b1;
  end

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_hit |-> (ld_edge == '0 && ld_store_pc == '0 && !ld_src_valid)); // R10

  AST_EVICT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> !ren_v[$past(lru_e)]); // R6

  AST_EVICT_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> own_v[$past(lru_e)]); // R5

  AST_STORE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hit && !(alloc && lru_e == st_edge)) |=>
      (ren_v[$past(st_edge)] && ren_p[$past(st_edge)] == $past(st_phys))); // R7

  AST_EVICT_BEATS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hit && alloc && lru_e == st_edge) |=> !ren_v[$past(st_edge)]); // R12

  AST_TOUCH_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> age[$past(touch_e)] == '0); // R9

  AST_AGE_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
    seen == '1); // R9
endmodule

bind memdep_edge_rename memdep_edge_rename_chk #(
  .PC_W(PC_W), .EDGE_W(EDGE_W), .PHYS_W(PHYS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_hit(ld_hit), .ld_store_pc(ld_store_pc),
  .ld_edge(ld_edge), .ld_src_valid(ld_src_valid), .st_hit(st_hit),
  .st_edge(st_edge), .st_phys(st_phys), .own_v(own_v), .ren_v(ren_v),
  .ren_p(ren_p), .age(age), .alloc(alloc), .lru_e(lru_e), .touch(touch),
  .touch_e(touch_e)
);

// File: tb/test_memdep_edge_rename.sv
module test_memdep_edge_rename;
  localparam int PC_W = 32, IDX_W = 4, TAG_W = 6, EDGE_W = 5, PHYS_W = 6;
  localparam int SETS = 16, EN = 32;

  logic clk = 0, rst_n = 0;
  logic trn_valid = 0, ld_req = 0, st_req = 0;
  logic [PC_W-1:0] trn_load_pc = 0, trn_store_pc = 0, ld_pc = 0, st_pc = 0;
  logic [PHYS_W-1:0] st_phys = 0;
  logic ld_hit, ld_src_valid, st_hit;
  logic [PC_W-1:0] ld_store_pc;
  logic [EDGE_W-1:0] ld_edge, st_edge;
  logic [PHYS_W-1:0] ld_src_phys;

  memdep_edge_rename #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .EDGE_W(EDGE_W), .PHYS_W(PHYS_W))
  i_memdep_edge_rename (
    .clk(clk), .rst_n(rst_n), .trn_valid(trn_valid), .trn_load_pc(trn_load_pc),
    .trn_store_pc(trn_store_pc), .ld_req(ld_req), .ld_pc(ld_pc), .ld_hit(ld_hit),
    .ld_store_pc(ld_store_pc), .ld_edge(ld_edge), .ld_src_valid(ld_src_valid),
    .ld_src_phys(ld_src_phys), .st_req(st_req), .st_pc(st_pc), .st_phys(st_phys),
    .st_hit(st_hit), .st_edge(st_edge));

  always #5 clk = ~clk;

  bit          m_lv [SETS];
  int unsigned m_ltag [SETS], m_lspc [SETS];
  int          m_le [SETS];
  bit          m_ov [EN], m_rv [EN];
  int unsigned m_own [EN];
  int          m_rp [EN];
  int          q [$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic int unsigned mk(int tag, int idx);
    return (tag << 6) | (idx << 2);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int m_find(int unsigned pc);
    for (int e = 0; e < EN; e++) if (m_ov[e] && m_own[e] == pc) return e;
    return -1;
  endfunction

  task automatic m_touch(int e);
    for (int k = 0; k < q.size(); k++) if (q[k] == e) begin q.delete(k); break; end
    q.push_back(e);
  endtask

  task automatic compare();
    int i = (ld_pc >> 2) % SETS;
    int unsigned tg = (ld_pc >> 6) & 63;
    int e = m_le[i];
    bit h = ld_req && m_lv[i] && m_ltag[i] == tg && m_ov[e] && m_own[e] == m_lspc[i];
    bit sv = h && m_rv[e];
    int s = st_req ? m_find(st_pc) : -1;
    chk("R2", "ld_hit", ld_hit, h);
    chk("R2", "ld_store_pc", ld_store_pc, h ? m_lspc[i] : 0);
    chk("R4", "ld_edge", ld_edge, h ? e : 0);
    chk("R6", "ld_src_valid", ld_src_valid, sv);
    chk("R7", "ld_src_phys", ld_src_phys, sv ? m_rp[e] : 0);
    chk("R8", "st_hit", st_hit, s >= 0);
    chk("R5", "st_edge", st_edge, s >= 0 ? s : 0);
  endtask

  task automatic update();
    int s = st_req ? m_find(st_pc) : -1;
    int te = -1;
    bit al = 0;
    if (trn_valid) begin
      te = m_find(trn_store_pc);
      if (te < 0) begin al = 1; te = q[0]; end
    end
    if (s >= 0 && !(al && te == s)) begin m_rv[s] = 1; m_rp[s] = st_phys; end
    if (al) begin m_ov[te] = 1; m_own[te] = trn_store_pc; m_rv[te] = 0; end
    if (trn_valid) begin
      int i = (trn_load_pc >> 2) % SETS;
      m_lv[i] = 1; m_ltag[i] = (trn_load_pc >> 6) & 63; m_lspc[i] = trn_store_pc; m_le[i] = te;
    end
    if (trn_valid) m_touch(te);
    else if (s >= 0) m_touch(s);
  endtask

  task automatic step();
    #1 compare();
    @(posedge clk);
    if (rst_n) update();
    @(negedge clk);
  endtask

  task automatic idle();
    trn_valid = 0; ld_req = 0; st_req = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hang expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    for (int e = EN - 1; e >= 0; e--) q.push_back(e);
    repeat (3) @(negedge clk);
    rst_n = 1;

    ld_req = 1; ld_pc = mk(1, 3); st_req = 1; st_pc = 'h1000;
    #1 chk("R1", "ld_hit after reset", ld_hit, 0);
    chk("R1", "st_hit after reset", st_hit, 0);
    step(); idle();

    trn_valid = 1; trn_load_pc = mk(1, 3); trn_store_pc = 'h1000; step(); idle();

    st_req = 1; st_pc = 'h1000; st_phys = 9; ld_req = 1; ld_pc = mk(1, 3);
    #1 chk("R1", "first edge name", st_edge, 31);
    chk("R2", "trained store pc", ld_store_pc, 'h1000);
    chk("R6", "unfilled mapping", ld_src_valid, 0);
    step(); idle();

    ld_req = 1; ld_pc = mk(1, 3);
    #1 chk("R7", "filled valid", ld_src_valid, 1);
    chk("R7", "filled phys", ld_src_phys, 9);
    step();
    ld_pc = mk(2, 3);
    #1 chk("R3", "tag alias", ld_hit, 0);
    chk("R10", "miss store pc", ld_store_pc, 0);
    step();
    ld_pc = mk(1, 4);
    #1 chk("R11", "other index", ld_hit, 0);
    step(); idle();

    trn_valid = 1; trn_load_pc = mk(5, 7); trn_store_pc = 'h1000; step(); idle();
    ld_req = 1; ld_pc = mk(5, 7);
    #1 chk("R4", "shared edge", ld_edge, 31);
    chk("R4", "shared phys", ld_src_phys, 9);
    step(); idle();

    trn_valid = 1; trn_load_pc = mk(6, 8); trn_store_pc = 'h2000; step(); idle();
    st_req = 1; st_pc = 'h2000; st_phys = 7;
    #1 chk("R5", "second edge", st_edge, 30);
    step(); idle();

    st_req = 1; st_pc = 'h3000; st_phys = 3;
    #1 chk("R8", "unknown store", st_hit, 0);
    step(); idle();
    ld_req = 1; ld_pc = mk(1, 3);
    #1 chk("R8", "mapping untouched", ld_src_phys, 9);
    step(); idle();

    st_req = 1; st_pc = 'h1000; st_phys = 9; step(); idle();
    for (int k = 0; k < 30; k++) begin
      trn_valid = 1; trn_load_pc = mk(20, 12); trn_store_pc = 'h4000 + k * 4; step();
    end
    trn_load_pc = mk(9, 9); trn_store_pc = 'h5000; step(); idle();

    st_req = 1; st_pc = 'h5000; st_phys = 1; ld_req = 1; ld_pc = mk(9, 9);
    #1 chk("R9", "recency spared edge 31", st_edge, 30);
    chk("R6", "reassigned edge invalid", ld_src_valid, 0);
    step();
    st_pc = 'h2000; ld_pc = mk(6, 8);
    #1 chk("R5", "evicted store", st_hit, 0);
    chk("R5", "evicted load", ld_hit, 0);
    step();
    st_pc = 'h1000; st_phys = 9;
    #1 chk("R9", "recent store kept", st_edge, 31);
    step(); idle();

    trn_valid = 1; trn_load_pc = mk(11, 11); trn_store_pc = 'h6000;
    st_req = 1; st_pc = 'h4000; st_phys = 5;
    #1 chk("R12", "store hits lru edge", st_edge, 29);
    step(); idle();
    ld_req = 1; ld_pc = mk(11, 11);
    #1 chk("R12", "eviction wins", ld_src_valid, 0);
    chk("R12", "new edge", ld_edge, 29);
    step(); idle();

    for (int c = 0; c < 3000; c++) begin
      trn_valid    = ($urandom % 4) == 0;
      trn_load_pc  = mk($urandom % 4, $urandom % SETS);
      trn_store_pc = 'h8000 + ($urandom % 48) * 4;
      ld_req       = ($urandom % 4) != 0;
      ld_pc        = mk($urandom % 4, $urandom % SETS);
      st_req       = ($urandom % 2) == 0;
      st_pc        = 'h8000 + ($urandom % 48) * 4;
      st_phys      = PHYS_W'($urandom);
      step();
    end
    idle();

    done = 1;
    summary();
    $finish;
  end
endmodule